// File: doc/BRIEF.md
# Stage-Bit Coefficient Corrector

This block turns the raw decision bits of a pipelined converter core into a calibrated output code. Each clock a sample of fifteen stage bits may arrive. Every bit position owns one signed fixed-point weight. The block adds the weights of the bits that are set, rounds the total to the nearest whole code, and limits it to a 12-bit straight-binary result. A flag marks results that had to be limited at the bottom or at the top of the range.

The weights sit in a small register file. A calibration controller outside this block loads it through a single write port. That port only takes effect while the calibration-active input is high. Samples stream at one per clock through a fixed pipeline. A valid bit travels with each sample so that gaps in the input stream come out as gaps at the output.

Top module: `stagebit_corrector`

## Requirements
- R1: For a valid sample, the block sums the weights whose stage bit is 1. Weights are two's-complement with 4 fractional bits. The sum is rounded to the nearest integer, with an exact half rounding upward, that is floor((sum+8)/16). A rounded result in 0..4095 appears on `out_code`.
- R2: `out_valid` rises exactly 7 clock edges after the edge that sampled `in_valid` high. Back-to-back samples come out back-to-back, in order.
- R3: A rounded result below 0 gives `out_code` = 0 with `out_over` = 1.
- R4: A rounded result above 4095 gives `out_code` = 4095 with `out_over` = 1.
- R5: The in-range ends are not flagged. A rounded result of exactly 0 or exactly 4095 gives `out_over` = 0.
- R6: A weight write with `cal_active` low is ignored, and later results still use the old weight.
- R7: A weight write to an address of 15 or above is ignored and changes no stored weight.
- R8: Synchronous reset clears `out_valid`, `out_over` and `out_code`, and sets every weight to zero. After reset, any sample therefore converts to code 0.
- R9: While `out_valid` is low, `out_over` is low and `out_code` keeps the last valid result.
- R10: Stage bit i of `in_raw` (bit 0 is the LSB of the port) selects the weight at write address i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cal_active | input | 1 | Calibration window; weight writes are accepted only while high |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | 4 | Weight index (stage bit number) |
| coef_wdata | input | 18 | Signed weight, 4 fractional bits |
| in_valid | input | 1 | Raw sample present |
| in_raw | input | 15 | Stage decision bits of one sample |
| out_valid | output | 1 | Corrected result present |
| out_code | output | 12 | Corrected straight-binary code |
| out_over | output | 1 | Result was limited at 0 or 4095 |

## Verification
Single bits set one at a time (a walking one) prove that bit i reaches weight i. These samples also land on the rounding threshold at a quarter code and at a half code. Random stage words, with binary weights loaded, exercise the full adder tree. Dense streams with random gaps separate latency and ordering faults from arithmetic faults. Hand-picked words and a negative weight place the rounded sum at -1, 0, 4095 and 4096. This shows whether the flag and the clamp switch at the right boundary. Writes with calibration low and writes to an unused address are followed by samples that would reveal any corrupted weight.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int unsigned STAGE_BITS_DEF = 15;
  localparam int unsigned COEF_BITS_DEF  = 18;
  localparam int unsigned FRAC_BITS_DEF  = 4;
  localparam int unsigned CODE_BITS_DEF  = 12;

  // number of registered adder levels needed to reduce n terms
  function automatic int unsigned tree_levels(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sbc_coef_bank.sv
module sbc_coef_bank #(
  parameter int unsigned N  = 15,
  parameter int unsigned W  = 18,
  parameter int unsigned AW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cal_active,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] coef_flat
);
  localparam logic [AW:0] N_LIM = (AW+1)'(N);

  logic [W-1:0] mem [N];
  logic         wr_ok;

  assign wr_ok = cal_active && wr_en && ({1'b0, wr_addr} < N_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(N); i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < int'(N); g++) begin : rd_g
    assign coef_flat[g*W +: W] = mem[g];
  end

  // R6
  cal_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(cal_active && wr_en) |=> $stable(coef_flat));

  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ({1'b0, wr_addr} >= N_LIM)) |=> $stable(coef_flat));
endmodule

// File: rtl/sbc_adder_tree.sv
module sbc_adder_tree #(
  parameter int unsigned N     = 15,
  parameter int unsigned IN_W  = 18,
  parameter int unsigned OUT_W = 22
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [N*IN_W-1:0]       terms,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] sum
);
  localparam int unsigned DEPTH  = sbc_pkg::tree_levels(N);
  localparam int unsigned LEAVES = 1 << DEPTH;

  for (genvar l = 0; l <= int'(DEPTH); l++) begin : lvl_g
    localparam int unsigned CNT = LEAVES >> l;
    if (l == 0) begin : stg
      logic signed [OUT_W-1:0] n [CNT];
      logic                    v;
      always_comb begin
        v = in_valid;
        for (int j = 0; j < int'(N); j++)
          n[j] = OUT_W'($signed(terms[j*IN_W +: IN_W]));
        for (int j = int'(N); j < int'(CNT); j++)
          n[j] = '0;
      end
    end else begin : stg
      logic signed [OUT_W-1:0] n [CNT];
      logic                    v;
      always_ff @(posedge clk) begin
        if (rst) v <= 1'b0;
        else     v <= lvl_g[l-1].stg.v;
        for (int j = 0; j < int'(CNT); j++)
          n[j] <= lvl_g[l-1].stg.n[2*j] + lvl_g[l-1].stg.n[2*j+1];
      end

      // R2
      lvl_valid_chk: assert property (@(posedge clk) disable iff (rst)
        v |-> $past(lvl_g[l-1].stg.v));
    end
  end

  assign sum       = lvl_g[DEPTH].stg.n[0];
  assign out_valid = lvl_g[DEPTH].stg.v;
endmodule

// File: rtl/sbc_saturate.sv
module sbc_saturate #(
  parameter int unsigned IN_W   = 22,
  parameter int unsigned FRAC   = 4,
  parameter int unsigned CODE_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] sum,
  output logic                   out_valid,
  output logic [CODE_W-1:0]      out_code,
  output logic                   out_over
);
  localparam int unsigned RW = IN_W + 1 - FRAC;
  localparam logic signed [IN_W:0]  HALF = (IN_W+1)'(1 << (FRAC - 1));
  localparam logic signed [RW-1:0]  TOP  = RW'((1 << CODE_W) - 1);

  logic signed [IN_W:0]  biased;
  logic signed [RW-1:0]  rounded;

  assign biased  = {sum[IN_W-1], sum} + HALF;
  assign rounded = RW'(biased >>> FRAC);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_over  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (!in_valid) begin
        out_over <= 1'b0;
      end else if (rounded < 0) begin
        out_code <= '0;
        out_over <= 1'b1;
      end else if (rounded > TOP) begin
        out_code <= '1;
        out_over <= 1'b1;
      end else begin
        out_code <= rounded[CODE_W-1:0];
        out_over <= 1'b0;
      end
    end
  end

  // R3 R4
  clamp_rail_chk: assert property (@(posedge clk) disable iff (rst)
    out_over |-> (out_code == '0 || out_code == '1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_over && $stable(out_code)));
endmodule

// File: rtl/stagebit_corrector.sv
module stagebit_corrector #(
  parameter int unsigned N_STAGE = sbc_pkg::STAGE_BITS_DEF,
  parameter int unsigned COEF_W  = sbc_pkg::COEF_BITS_DEF,
  parameter int unsigned FRAC_W  = sbc_pkg::FRAC_BITS_DEF,
  parameter int unsigned CODE_W  = sbc_pkg::CODE_BITS_DEF,
  parameter int unsigned AW      = $clog2(N_STAGE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_active,
  input  logic              coef_we,
  input  logic [AW-1:0]     coef_addr,
  input  logic [COEF_W-1:0] coef_wdata,
  input  logic              in_valid,
  input  logic [N_STAGE-1:0] in_raw,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_over
);
  localparam int unsigned LEVELS = sbc_pkg::tree_levels(N_STAGE);
  localparam int unsigned SUM_W  = COEF_W + LEVELS;

  logic [N_STAGE*COEF_W-1:0] coef_flat;
  logic [N_STAGE-1:0]        raw_q;
  logic                      raw_v;
  logic [N_STAGE*COEF_W-1:0] terms_q;
  logic                      terms_v;
  logic                      sum_v;
  logic signed [SUM_W-1:0]   sum;

  sbc_coef_bank #(.N(N_STAGE), .W(COEF_W), .AW(AW)) bank_i (
    .clk(clk), .rst(rst), .cal_active(cal_active), .wr_en(coef_we),
    .wr_addr(coef_addr), .wr_data(coef_wdata), .coef_flat(coef_flat)
  );

  // capture the raw sample
  always_ff @(posedge clk) begin
    if (rst) raw_v <= 1'b0;
    else     raw_v <= in_valid;
    raw_q <= in_raw;
  end

  // gate each stage weight by its stage bit
  always_ff @(posedge clk) begin
    if (rst) terms_v <= 1'b0;
    else     terms_v <= raw_v;
    for (int i = 0; i < int'(N_STAGE); i++)
      terms_q[i*COEF_W +: COEF_W] <= raw_q[i] ? coef_flat[i*COEF_W +: COEF_W] : '0;
  end

  sbc_adder_tree #(.N(N_STAGE), .IN_W(COEF_W), .OUT_W(SUM_W)) tree_i (
    .clk(clk), .rst(rst), .in_valid(terms_v), .terms(terms_q),
    .out_valid(sum_v), .sum(sum)
  );

  sbc_saturate #(.IN_W(SUM_W), .FRAC(FRAC_W), .CODE_W(CODE_W)) sat_i (
    .clk(clk), .rst(rst), .in_valid(sum_v), .sum(sum),
    .out_valid(out_valid), .out_code(out_code), .out_over(out_over)
  );

  // R2
  stage_valid_chk: assert property (@(posedge clk) disable iff (rst)
    terms_v |-> $past(raw_v));
endmodule

// File: tb/stagebit_corrector_tb_top.sv
module stagebit_corrector_tb_top;
  localparam int LAT = 7;

  logic        clk = 1'b0;
  logic        rst;
  logic        cal_active;
  logic        coef_we;
  logic [3:0]  coef_addr;
  logic [17:0] coef_wdata;
  logic        in_valid;
  logic [14:0] in_raw;
  logic        out_valid;
  logic [11:0] out_code;
  logic        out_over;

  always #5 clk = ~clk;

  stagebit_corrector dut_i (
    .clk(clk), .rst(rst), .cal_active(cal_active), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_wdata(coef_wdata), .in_valid(in_valid),
    .in_raw(in_raw), .out_valid(out_valid), .out_code(out_code), .out_over(out_over)
  );

  typedef struct {
    bit    v;
    int    code;
    bit    over;
    string tag;
  } exp_t;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  int   coef_m [15];
  exp_t q [$];
  int   held_code = 0;

  function automatic exp_t model(input bit v, input logic [14:0] raw, input string tag);
    exp_t e;
    int s = 0;
    int r;
    for (int i = 0; i < 15; i++) if (raw[i]) s += coef_m[i];
    r = (s + 8) >>> 4;
    e.v = v;
    e.tag = v ? tag : "R9";
    if (r < 0)         begin e.code = 0;    e.over = 1; end
    else if (r > 4095) begin e.code = 4095; e.over = 1; end
    else               begin e.code = r;    e.over = 0; end
    return e;
  endfunction

  task automatic step(input bit v, input logic [14:0] raw, input string tag,
                      input bit cal = 0, input bit we = 0,
                      input int addr = 0, input int data = 0);
    exp_t e;
    int   ec;
    bit   eo;
    @(negedge clk);
    if (q.size() == LAT) begin
      e  = q.pop_front();
      ec = e.v ? e.code : held_code;
      eo = e.v ? e.over : 1'b0;
      if (e.v) held_code = e.code;
      checks++;
      if (out_valid !== e.v || int'(out_code) != ec || out_over !== eo) begin
        errors++;
        $display("FAIL %s (R2 timing if valid differs): valid/code/over act %0d/%0d/%0d exp %0d/%0d/%0d",
                 e.tag, out_valid, out_code, out_over, e.v, ec, eo);
      end
    end
    in_valid   = v;
    in_raw     = raw;
    cal_active = cal;
    coef_we    = we;
    coef_addr  = 4'(addr);
    coef_wdata = 18'(data);
    q.push_back(model(v, raw, tag));
    if (cal && we && addr < 15) coef_m[addr] = data;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 15'h0, "R9");
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: act running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) coef_m[i] = 0;
    rst = 1'b1; cal_active = 0; coef_we = 0; coef_addr = 0; coef_wdata = 0;
    in_valid = 0; in_raw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_code !== 12'd0 || out_over !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: valid/code/over act %0d/%0d/%0d exp 0/0/0", out_valid, out_code, out_over);
    end
    rst = 1'b0;
    for (int k = 0; k < LAT; k++) q.push_back(model(1'b0, 15'h0, "R8"));

    // R8: weights cleared by reset
    step(1'b1, 15'h7FFF, "R8");
    idle(2);

    // load binary weights 2^(i+1) sixteenths
    for (int i = 0; i < 15; i++) step(1'b0, 15'h0, "R9", 1'b1, 1'b1, i, 2 << i);
    idle(1);

    // R10: walking one, includes quarter and half code rounding
    for (int i = 0; i < 15; i++) step(1'b1, 15'(1 << i), "R10");
    idle(1);

    // R1: rounding and random words
    step(1'b1, 15'd4, "R1");
    step(1'b1, 15'd3, "R1");
    step(1'b1, 15'd12, "R1");
    for (int k = 0; k < 20; k++) step(1'b1, 15'($urandom_range(0, 32767)), "R1");

    // R5: range ends not flagged
    step(1'b1, 15'h0000, "R5");
    step(1'b1, 15'h7FF8, "R5");
    // R4: above top
    step(1'b1, 15'h7FFC, "R4");
    step(1'b1, 15'h7FFF, "R4");
    idle(2);

    // R6: write with calibration low is ignored
    step(1'b0, 15'h0, "R9", 1'b0, 1'b1, 0, 5000);
    step(1'b1, 15'h0001, "R6");
    step(1'b1, 15'h0007, "R6");
    // R7: out-of-range address ignored
    step(1'b0, 15'h0, "R9", 1'b1, 1'b1, 15, 9999);
    for (int k = 0; k < 15; k++) step(1'b1, 15'(1 << k), "R7");
    step(1'b1, 15'h7FF8, "R7");

    // R3: negative sums, boundary at -1 and 0
    step(1'b0, 15'h0, "R9", 1'b1, 1'b1, 14, -8);
    step(1'b1, 15'h4000, "R5");
    step(1'b0, 15'h0, "R9", 1'b1, 1'b1, 14, -9);
    step(1'b1, 15'h4000, "R3");
    step(1'b0, 15'h0, "R9", 1'b1, 1'b1, 14, -40000);
    step(1'b1, 15'h4000, "R3");
    step(1'b1, 15'h4001, "R3");
    step(1'b1, 15'h7FFF, "R3");
    step(1'b0, 15'h0, "R9", 1'b1, 1'b1, 14, 1 << 15);
    idle(1);

    // R2: dense stream, then stream with random gaps (R9 hold)
    for (int k = 0; k < 40; k++) step(1'b1, 15'($urandom_range(0, 32767)), "R2");
    for (int k = 0; k < 60; k++)
      step(1'($urandom_range(0, 1)), 15'($urandom_range(0, 32767)), "R2");
    idle(LAT + 3);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule